// File: doc/BRIEF.md
# Host Command Packet Responder with Seconds Clock

This block sits behind a byte-level transfer handshake and acts on complete packets that the host has sent. When a packet arrives, its first byte selects the packet class and, for controller commands, its second byte selects the operation. The block carries out the operation and presents a reply packet, with its length and a one-cycle valid strobe, for the transfer logic to send back to the host.

The block keeps a 32-bit seconds value. Software can load it and read it back, and a one-second tick input advances it. The block also keeps a polling enable. While polling is on, every tick of an external 50 Hz poll input is passed on as a poll request. Power-down and system-reset commands are acknowledged first, and the matching request pulse follows on the next cycle.

Top module: `pkt_responder`

## Requirements
- R1: A reply is presented in the cycle after the packet strobe, with `rplValid` high for exactly one cycle. A packet produces no reply and changes no state if its length is zero, if its class byte is 2 to 255, if its command is not one listed here, or if it is shorter than its command needs.
- R2: Reply byte i sits on `rplData` bits 8i+7 down to 8i. `rplLen` gives the byte count. Bytes beyond `rplLen` are zero.
- R3: A packet whose byte 0 is 0x00 (peripheral-bus class) gets the reply {0x00, 0x00}.
- R4: The command 0x03 in a class-1 packet (byte 0 = 0x01) returns 7 bytes: {0x01, 0x00, 0x00}, followed by the seconds value as it stood when the packet arrived, most significant byte first.
- R5: The command 0x09 needs a length of at least 6. Bytes 2 to 5, most significant first, are loaded into the seconds value, and the reply is {0x01, 0x00, 0x00}. If a one-second tick arrives in the same cycle, the load wins.
- R6: Each `secTick` cycle without a load adds one to the seconds value, which wraps from 0xFFFFFFFF to 0.
- R7: The command 0x01 needs a length of at least 3. It replies {0x01, arg}, where arg is byte 2. Polling turns on when arg is nonzero and off when arg is zero. `pollReq` equals `pollTick` while polling is on and stays low while it is off.
- R8: The command 0x0A (power down) and the command 0x11 (system reset) each reply {0x01, 0x00}. One cycle after their reply, `pwrOffReq` or `sysRstReq` respectively pulses high for one cycle.
- R9: The commands 0x13, 0x14, 0x19 and 0x21 reply {0x01, 0x00} and have no other effect.
- R10: After reset the seconds value is 0, polling is off, and `rplValid`, `rplLen`, `pwrOffReq` and `sysRstReq` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pktValid | input | 1 | Strobe: one received packet is present |
| pktLen | input | 4 | Received packet length in bytes |
| pktData | input | 64 | Received bytes, byte i at bits 8i+7:8i |
| secTick | input | 1 | One-second tick |
| pollTick | input | 1 | 50 Hz poll tick |
| rplValid | output | 1 | Strobe: reply is ready |
| rplLen | output | 4 | Reply length in bytes |
| rplData | output | 64 | Reply bytes, byte i at bits 8i+7:8i |
| pollReq | output | 1 | Poll request, gated by the polling enable |
| pwrOffReq | output | 1 | Power-down request pulse |
| sysRstReq | output | 1 | System-reset request pulse |

## Verification
The reply, the seconds load and any change to the polling enable all take effect at the clock edge that samples the packet strobe, so they are visible one cycle after the strobe. The power and reset pulses come one cycle after that. `pollReq` follows `pollTick` within the same cycle. The bench drives every input on the falling edge and reads the reply at the next falling edge. It reads the request pulses one falling edge later, and it probes `pollReq` a moment after raising `pollTick`. It keeps its own model of the seconds value and of the polling enable. Each model update follows the R5 and R6 ordering, so a get issued together with a tick returns the value from before the tick.

// File: rtl/pkt_responder_pkg.sv
package pkt_responder_pkg;
  localparam int TIME_BYTES = 4;
  localparam int SEC_W = 8 * TIME_BYTES;

  localparam logic [7:0] CLS_BUS = 8'h00;
  localparam logic [7:0] CLS_CMD = 8'h01;

  localparam logic [7:0] OP_AUTOPOLL = 8'h01;
  localparam logic [7:0] OP_GETTIME  = 8'h03;
  localparam logic [7:0] OP_SETTIME  = 8'h09;
  localparam logic [7:0] OP_PWROFF   = 8'h0A;
  localparam logic [7:0] OP_SYSRST   = 8'h11;
  localparam logic [7:0] OP_NOP_A    = 8'h13;
  localparam logic [7:0] OP_NOP_B    = 8'h14;
  localparam logic [7:0] OP_NOP_C    = 8'h19;
  localparam logic [7:0] OP_NOP_D    = 8'h21;

  typedef enum logic [2:0] {
    RK_NONE, RK_BUSSTAT, RK_ECHO, RK_ACK2, RK_ACK3, RK_TIME
  } replyKind_e;

  typedef struct packed {
    logic       loadTime;
    logic       pollWr;
    logic       pollVal;
    logic       offPulse;
    logic       rstPulse;
    replyKind_e kind;
  } ctrlStrobe_t;
endpackage

// File: rtl/pkt_resp_ctrl.sv
module pkt_resp_ctrl
  import pkt_responder_pkg::*;
#(
  parameter int MAX_BYTES = 8,
  parameter int LEN_W = 4
) (
  input  logic                   pktValid,
  input  logic [LEN_W-1:0]       pktLen,
  input  logic [8*MAX_BYTES-1:0] pktData,
  output ctrlStrobe_t            strb
);
  logic [7:0] pktClass, opCode, opArg;

  assign pktClass = pktData[7:0];
  assign opCode   = pktData[15:8];
  assign opArg    = pktData[23:16];

  always_comb begin
    strb = '0;
    strb.kind = RK_NONE;
    if (pktValid && pktLen != '0) begin
      if (pktClass == CLS_BUS) begin
        strb.kind = RK_BUSSTAT;
      end else if (pktClass == CLS_CMD && pktLen >= LEN_W'(2)) begin
        case (opCode)
          OP_AUTOPOLL: if (pktLen >= LEN_W'(3)) begin
            strb.pollWr  = 1'b1;
            strb.pollVal = |opArg;
            strb.kind    = RK_ECHO;
          end
          OP_GETTIME: strb.kind = RK_TIME;
          OP_SETTIME: if (pktLen >= LEN_W'(2 + TIME_BYTES)) begin
            strb.loadTime = 1'b1;
            strb.kind     = RK_ACK3;
          end
          OP_NOP_A, OP_NOP_B, OP_NOP_C, OP_NOP_D: strb.kind = RK_ACK2;
          OP_PWROFF: begin
            strb.kind     = RK_ACK2;
            strb.offPulse = 1'b1;
          end
          OP_SYSRST: begin
            strb.kind     = RK_ACK2;
            strb.rstPulse = 1'b1;
          end
          default: strb.kind = RK_NONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/pkt_resp_dp.sv
module pkt_resp_dp
  import pkt_responder_pkg::*;
#(
  parameter int MAX_BYTES = 8,
  parameter int LEN_W = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobe_t            strb,
  input  logic [8*MAX_BYTES-1:0] pktData,
  input  logic                   secTick,
  input  logic                   pollTick,
  output logic                   rplValid,
  output logic [LEN_W-1:0]       rplLen,
  output logic [8*MAX_BYTES-1:0] rplData,
  output logic                   pollReq,
  output logic                   pwrOffReq,
  output logic                   sysRstReq
);
  logic [SEC_W-1:0]       secCount, setVal;
  logic                   pollOn, offPend, rstPend;
  logic [8*MAX_BYTES-1:0] nextData;
  logic [LEN_W-1:0]       nextLen;

  always_comb begin
    for (int i = 0; i < TIME_BYTES; i++)
      setVal[8*(TIME_BYTES-1-i) +: 8] = pktData[8*(2+i) +: 8];
  end

  always_comb begin
    nextData = '0;
    nextLen  = '0;
    case (strb.kind)
      RK_BUSSTAT: nextLen = LEN_W'(2);
      RK_ECHO: begin
        nextData[7:0]  = CLS_CMD;
        nextData[15:8] = pktData[23:16];
        nextLen        = LEN_W'(2);
      end
      RK_ACK2: begin
        nextData[7:0] = CLS_CMD;
        nextLen       = LEN_W'(2);
      end
      RK_ACK3: begin
        nextData[7:0] = CLS_CMD;
        nextLen       = LEN_W'(3);
      end
      RK_TIME: begin
        nextData[7:0] = CLS_CMD;
        for (int i = 0; i < TIME_BYTES; i++)
          nextData[8*(3+i) +: 8] = secCount[8*(TIME_BYTES-1-i) +: 8];
        nextLen = LEN_W'(3 + TIME_BYTES);
      end
      default: nextLen = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      secCount  <= '0;
      pollOn    <= 1'b0;
      rplValid  <= 1'b0;
      rplLen    <= '0;
      rplData   <= '0;
      offPend   <= 1'b0;
      rstPend   <= 1'b0;
      pwrOffReq <= 1'b0;
      sysRstReq <= 1'b0;
    end else begin
      if (strb.loadTime)   secCount <= setVal;
      else if (secTick)    secCount <= secCount + 1'b1;
      if (strb.pollWr)     pollOn <= strb.pollVal;
      rplValid <= (strb.kind != RK_NONE);
      if (strb.kind != RK_NONE) begin
        rplLen  <= nextLen;
        rplData <= nextData;
      end
      offPend   <= strb.offPulse;
      rstPend   <= strb.rstPulse;
      pwrOffReq <= offPend;
      sysRstReq <= rstPend;
    end
  end

  assign pollReq = pollTick & pollOn;
endmodule

// File: rtl/pkt_responder.sv
module pkt_responder
  import pkt_responder_pkg::*;
#(
  parameter int MAX_BYTES = 8,
  localparam int LEN_W = $clog2(MAX_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   pktValid,
  input  logic [LEN_W-1:0]       pktLen,
  input  logic [8*MAX_BYTES-1:0] pktData,
  input  logic                   secTick,
  input  logic                   pollTick,
  output logic                   rplValid,
  output logic [LEN_W-1:0]       rplLen,
  output logic [8*MAX_BYTES-1:0] rplData,
  output logic                   pollReq,
  output logic                   pwrOffReq,
  output logic                   sysRstReq
);
  ctrlStrobe_t strb;

  pkt_resp_ctrl #(.MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W)) u_ctrl (
    .pktValid(pktValid), .pktLen(pktLen), .pktData(pktData), .strb(strb)
  );

  pkt_resp_dp #(.MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .pktData(pktData),
    .secTick(secTick), .pollTick(pollTick),
    .rplValid(rplValid), .rplLen(rplLen), .rplData(rplData),
    .pollReq(pollReq), .pwrOffReq(pwrOffReq), .sysRstReq(sysRstReq)
  );
endmodule

// File: rtl/pkt_responder_chk.sv
module pkt_responder_chk #(
  parameter int MAX_BYTES = 8,
  parameter int LEN_W = 4
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   pktValid,
  input logic                   pollTick,
  input logic                   rplValid,
  input logic [LEN_W-1:0]       rplLen,
  input logic [8*MAX_BYTES-1:0] rplData,
  input logic                   pollReq,
  input logic                   pwrOffReq,
  input logic                   sysRstReq
);
  // R1
  reply_needs_packet_chk: assert property (@(posedge clk) disable iff (!rstN)
    rplValid |-> $past(pktValid));

  // R2
  reply_len_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    rplValid |-> (rplLen == LEN_W'(2) || rplLen == LEN_W'(3) || rplLen == LEN_W'(7)));

  // R4
  time_header_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rplValid && rplLen == LEN_W'(7)) |-> (rplData[23:0] == 24'h000001));

  // R7
  poll_gated_chk: assert property (@(posedge clk) disable iff (!rstN)
    pollReq |-> pollTick);

  // R8
  off_after_reply_chk: assert property (@(posedge clk) disable iff (!rstN)
    pwrOffReq |-> $past(rplValid));

  // R8
  rst_after_reply_chk: assert property (@(posedge clk) disable iff (!rstN)
    sysRstReq |-> $past(rplValid));

  // R8
  req_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({pwrOffReq, sysRstReq}));
endmodule

bind pkt_responder pkt_responder_chk #(.MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rstN(rstN), .pktValid(pktValid), .pollTick(pollTick),
  .rplValid(rplValid), .rplLen(rplLen), .rplData(rplData),
  .pollReq(pollReq), .pwrOffReq(pwrOffReq), .sysRstReq(sysRstReq)
);

// File: tb/sim_pkt_responder.sv
module sim_pkt_responder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pktValid = 1'b0;
  logic [3:0]  pktLen = '0;
  logic [63:0] pktData = '0;
  logic        secTick = 1'b0;
  logic        pollTick = 1'b0;
  logic        rplValid;
  logic [3:0]  rplLen;
  logic [63:0] rplData;
  logic        pollReq, pwrOffReq, sysRstReq;

  int nChecks = 0;
  int nErrs = 0;
  bit finished = 0;

  logic [31:0] secsM = '0;
  logic        pollM = 1'b0;

  always #2.5 clk = ~clk;

  pkt_responder u0 (
    .clk(clk), .rstN(rstN), .pktValid(pktValid), .pktLen(pktLen),
    .pktData(pktData), .secTick(secTick), .pollTick(pollTick),
    .rplValid(rplValid), .rplLen(rplLen), .rplData(rplData),
    .pollReq(pollReq), .pwrOffReq(pwrOffReq), .sysRstReq(sysRstReq)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nErrs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [63:0] mk(input logic [7:0] b0, b1, b2, b3, b4, b5);
    return {16'h0, b5, b4, b3, b2, b1, b0};
  endfunction

  // Independent model of the reply for one packet (R1..R9)
  task automatic predict(input logic [3:0] len, input logic [63:0] d,
                         output bit v, output logic [3:0] eLen, output logic [63:0] eData,
                         output bit load, output logic [31:0] newSecs, output bit offE, output bit rstE);
    v = 0; eLen = 0; eData = 0; load = 0; newSecs = 0; offE = 0; rstE = 0;
    if (len != 0) begin
      if (d[7:0] == 8'h00) begin
        v = 1; eLen = 2;
      end else if (d[7:0] == 8'h01 && len >= 2) begin
        case (d[15:8])
          8'h01: if (len >= 3) begin
            v = 1; eLen = 2; eData[7:0] = 8'h01; eData[15:8] = d[23:16];
            pollM = (d[23:16] != 0);
          end
          8'h03: begin
            v = 1; eLen = 7; eData[7:0] = 8'h01;
            eData[31:24] = secsM[31:24]; eData[39:32] = secsM[23:16];
            eData[47:40] = secsM[15:8];  eData[55:48] = secsM[7:0];
          end
          8'h09: if (len >= 6) begin
            v = 1; eLen = 3; eData[7:0] = 8'h01; load = 1;
            newSecs = {d[23:16], d[31:24], d[39:32], d[47:40]};
          end
          8'h13, 8'h14, 8'h19, 8'h21: begin v = 1; eLen = 2; eData[7:0] = 8'h01; end
          8'h0A: begin v = 1; eLen = 2; eData[7:0] = 8'h01; offE = 1; end
          8'h11: begin v = 1; eLen = 2; eData[7:0] = 8'h01; rstE = 1; end
          default: v = 0;
        endcase
      end
    end
  endtask

  task automatic sendPkt(input logic [3:0] len, input logic [63:0] d, input bit tick, input string tag);
    bit v, load, offE, rstE;
    logic [3:0] eLen;
    logic [63:0] eData;
    logic [31:0] newSecs;
    predict(len, d, v, eLen, eData, load, newSecs, offE, rstE);
    pktValid = 1; pktLen = len; pktData = d; secTick = tick;
    step();
    pktValid = 0; pktLen = 0; pktData = 0; secTick = 0;
    if (load) secsM = newSecs;
    else if (tick) secsM = secsM + 1;
    chk(rplValid == v, {tag, " R1 valid"}, 64'(rplValid), 64'(v));
    if (v) begin
      chk(rplLen == eLen, {tag, " R2 len"}, 64'(rplLen), 64'(eLen));
      chk(rplData == eData, {tag, " R2 data"}, rplData, eData);
    end
    chk(!pwrOffReq && !sysRstReq, {tag, " R8 early"}, 64'({pwrOffReq, sysRstReq}), 64'h0);
    step();
    chk(!rplValid, {tag, " R1 single"}, 64'(rplValid), 64'h0);
    chk(pwrOffReq == offE && sysRstReq == rstE, {tag, " R8 pulse"},
        64'({pwrOffReq, sysRstReq}), 64'({offE, rstE}));
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      secTick = 1;
      step();
      secsM = secsM + 1;
    end
    secTick = 0;
  endtask

  task automatic pollProbe(input string tag);
    pollTick = 1;
    #1;
    chk(pollReq == pollM, {tag, " R7 pollReq"}, 64'(pollReq), 64'(pollM));
    pollTick = 0;
    #1;
    chk(!pollReq, {tag, " R7 idle"}, 64'(pollReq), 64'h0);
  endtask

  function automatic logic [63:0] getPkt();
    return mk(8'h01, 8'h03, 0, 0, 0, 0);
  endfunction

  function automatic logic [63:0] setPkt(input logic [31:0] t);
    return mk(8'h01, 8'h09, t[31:24], t[23:16], t[15:8], t[7:0]);
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      nErrs++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrs);
      $finish;
    end
  end

  initial begin
    logic [7:0] ops [10];
    void'($urandom(32'd1234));
    ops = '{8'h01, 8'h03, 8'h09, 8'h13, 8'h14, 8'h19, 8'h21, 8'h0A, 8'h11, 8'h07};
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!rplValid && rplLen == 0 && !pwrOffReq && !sysRstReq, "R10 reset outs",
        64'({rplValid, rplLen, pwrOffReq, sysRstReq}), 64'h0);
    rstN = 1;
    step();
    pollProbe("R10 poll off");
    sendPkt(2, getPkt(), 0, "R10 R4 time zero");

    // R5 / R4
    sendPkt(6, setPkt(32'h12345678), 0, "R5 set");
    sendPkt(2, getPkt(), 0, "R4 get");
    // R6 ticks and wrap
    ticks(3);
    sendPkt(2, getPkt(), 0, "R6 after ticks");
    sendPkt(6, setPkt(32'hFFFFFFFF), 0, "R6 set max");
    ticks(1);
    sendPkt(2, getPkt(), 0, "R6 wrap");
    // R5 load beats coincident tick
    sendPkt(6, setPkt(32'hA0B0C0D0), 1, "R5 load vs tick");
    sendPkt(2, getPkt(), 0, "R5 readback");
    // R4 get with coincident tick returns pre-tick value
    sendPkt(2, getPkt(), 1, "R4 get with tick");
    sendPkt(2, getPkt(), 0, "R6 tick during get");
    // R3
    sendPkt(1, mk(8'h00, 0, 0, 0, 0, 0), 0, "R3 bus");
    sendPkt(5, mk(8'h00, 8'h55, 8'h66, 0, 0, 0), 0, "R3 bus long");
    // R7
    sendPkt(3, mk(8'h01, 8'h01, 8'h05, 0, 0, 0), 0, "R7 poll on");
    pollProbe("R7 on");
    sendPkt(2, mk(8'h01, 8'h01, 8'h00, 0, 0, 0), 0, "R1 short autopoll");
    pollProbe("R1 short autopoll kept");
    sendPkt(3, mk(8'h01, 8'h01, 8'h00, 0, 0, 0), 0, "R7 poll off");
    pollProbe("R7 off");
    // R1 ignored packets
    sendPkt(4, mk(8'h03, 8'h09, 0, 0, 0, 0), 0, "R1 class3");
    sendPkt(6, mk(8'h02, 8'h09, 1, 2, 3, 4), 0, "R1 class2");
    sendPkt(2, mk(8'h01, 8'h07, 0, 0, 0, 0), 0, "R1 unknown op");
    sendPkt(5, mk(8'h01, 8'h09, 9, 9, 9, 9), 0, "R1 short set");
    sendPkt(0, mk(8'h00, 0, 0, 0, 0, 0), 0, "R1 zero len");
    sendPkt(1, mk(8'h01, 8'h03, 0, 0, 0, 0), 0, "R1 short cmd");
    sendPkt(2, getPkt(), 0, "R1 state unchanged");
    // R9 no-effect acks
    sendPkt(3, mk(8'h01, 8'h13, 8'hFF, 0, 0, 0), 0, "R9 op13");
    sendPkt(2, mk(8'h01, 8'h14, 0, 0, 0, 0), 0, "R9 op14");
    sendPkt(2, mk(8'h01, 8'h19, 0, 0, 0, 0), 0, "R9 op19");
    sendPkt(2, mk(8'h01, 8'h21, 0, 0, 0, 0), 0, "R9 op21");
    pollProbe("R9 poll untouched");
    sendPkt(2, getPkt(), 0, "R9 time untouched");
    // R8
    sendPkt(2, mk(8'h01, 8'h0A, 0, 0, 0, 0), 0, "R8 power off");
    sendPkt(2, mk(8'h01, 8'h11, 0, 0, 0, 0), 0, "R8 sys reset");

    // Random mix
    for (int it = 0; it < 80; it++) begin
      logic [7:0] op;
      logic [3:0] len;
      logic [63:0] d;
      ticks($urandom_range(0, 3));
      op = ops[$urandom_range(0, 9)];
      len = 4'($urandom_range(1, 8));
      d = {$urandom, $urandom};
      d[7:0] = ($urandom_range(0, 9) == 0) ? 8'h00 : 8'h01;
      d[15:8] = op;
      if ($urandom_range(0, 3) == 0) d[23:16] = 8'h00;
      sendPkt(len, d, 1'($urandom_range(0, 1)), "rand R1 R2");
      pollProbe("rand R7");
    end
    sendPkt(2, getPkt(), 0, "final R4 R6");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrs);
    $finish;
  end
endmodule